// File: doc/BRIEF.md
# I2C Master Arbitration-Loss Guard

This block sits beside the bit engine of an I2C controller on a bus that carries more than one master. While the local controller holds the master role, the block samples the bus on every rising edge of SCL. It compares the level the engine is driving onto SDA with the level that is actually on the wire. A mismatch means another master pulled SDA low while the local engine released it, or the reverse. The local controller has then lost arbitration and must get off the bus.

On a loss the block latches a sticky arbitration-lost flag. In the same clock it drops the master and transmit mode bits, so the controller continues as a slave receiver. From that point it releases its SCL output, so its clock stops. It also keeps its SDA output released until the engine marks the end of the current byte. Software sees the flag and the two mode bits. The flag clears when the data buffer is read or written, or when the second control register is written. A write to that control register also loads new mode bits. The bus inputs pass through a two-stage synchronizer before any edge is detected.

Top module: `i2c_arb_guard`

## Requirements
- R1: After reset the flag, master bit and transmit bit are 0, scl_o is 1, and sda_o equals sda_drive_i.
- R2: A compare happens at a rising SCL edge while the master bit is 1 and drive_slot_i is 1. If the synchronized SDA level differs from sda_drive_i, the flag reads 1 on the third rising clk edge after scl_i is first sampled high.
- R3: The clock edge that sets the flag also clears the master bit and the transmit bit.
- R4: No loss is flagged when the levels match, when drive_slot_i is 0 (acknowledge slot) or when the master bit is 0.
- R5: Once set, the flag stays 1 until a pulse on dbr_wr_i, dbr_rd_i or cr2_we_i. It reads 0 after the clock edge that samples that pulse.
- R6: A clear pulse sampled on the same edge as a new loss leaves the flag at 1 and the mode bits at 0, even when the pulse is a control write.
- R7: From the edge that flags a loss, sda_o is 1 whatever sda_drive_i is. It follows sda_drive_i again after the edge that samples byte_end_i high.
- R8: scl_o equals scl_drive_i while the master bit is 1 and is 1 otherwise.
- R9: A cr2_we_i pulse loads mst_wdata_i and trx_wdata_i into the master and transmit bits on the sampling edge.
- R10: An SDA mismatch that appears while SCL stays high causes no loss; only the low-to-high transition of SCL triggers a compare.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | SCL level seen on the bus |
| sda_i | input | 1 | SDA level seen on the bus |
| scl_drive_i | input | 1 | SCL level requested by the bit engine |
| sda_drive_i | input | 1 | SDA level requested by the bit engine (1 = released) |
| drive_slot_i | input | 1 | Engine is sending an address or data bit |
| byte_end_i | input | 1 | End-of-byte pulse from the engine |
| dbr_wr_i | input | 1 | Data buffer write strobe |
| dbr_rd_i | input | 1 | Data buffer read strobe |
| cr2_we_i | input | 1 | Control register 2 write strobe |
| mst_wdata_i | input | 1 | Master bit value carried by a control write |
| trx_wdata_i | input | 1 | Transmit bit value carried by a control write |
| al_o | output | 1 | Sticky arbitration-lost flag |
| mst_o | output | 1 | Master mode bit |
| trx_o | output | 1 | Transmit mode bit |
| sda_o | output | 1 | SDA level driven toward the pad |
| scl_o | output | 1 | SCL level driven toward the pad |

## Verification
The loss result is due three clock edges after the first edge that samples SCL high: two synchronizer stages and then the state register. The mode bits change on that same edge. Register strobes act one edge after they are sampled. The SCL and SDA outputs follow the engine inputs in the same cycle. The bench model pushes the raw bus levels into a history queue each clock and takes the compare operands from the entry two edges old, so it lands on the same edge as the design. The bench compares all five outputs one nanosecond after every rising clk edge. Directed checks are made on falling edges, after the last register on the path has updated.

// File: rtl/i2c_arb_pkg.sv
package i2c_arb_pkg;

  typedef struct packed {
    logic scl;
    logic sda;
  } bus_lvl_t;

  typedef struct packed {
    logic mst;
    logic trx;
  } arb_mode_t;

  localparam bus_lvl_t BUS_IDLE = '{scl: 1'b1, sda: 1'b1};

endpackage

// File: rtl/i2c_arb_sync.sv
module i2c_arb_sync #(
  parameter int WIDTH = 2,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  localparam int CHAIN_W = WIDTH * STAGES;

  logic [CHAIN_W-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= {STAGES{RST_VAL}};
    else         chain_q <= {chain_q[CHAIN_W-WIDTH-1:0], d_i};
  end

  assign q_o = chain_q[CHAIN_W-1 -: WIDTH];

endmodule

// File: rtl/i2c_arb_edge.sv
module i2c_arb_edge #(
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic rise_o
);

  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= RST_VAL;
    else         prev_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~prev_q;

endmodule

// File: rtl/i2c_arb_core.sv
module i2c_arb_core
  import i2c_arb_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      scl_rise_i,
  input  logic      sda_seen_i,
  input  logic      sda_drive_i,
  input  logic      drive_slot_i,
  input  logic      byte_end_i,
  input  logic      dbr_wr_i,
  input  logic      dbr_rd_i,
  input  logic      cr2_we_i,
  input  arb_mode_t mode_wdata_i,
  output logic      al_o,
  output arb_mode_t mode_o,
  output logic      hold_o
);

  logic      al_q;
  logic      hold_q;
  arb_mode_t mode_q;
  logic      cmp_en;
  logic      loss;
  logic      clr;

  // compare only while this side owns the bit on the wire
  assign cmp_en = mode_q.mst & drive_slot_i & scl_rise_i;
  assign loss   = cmp_en & (sda_seen_i ^ sda_drive_i);
  assign clr    = dbr_wr_i | dbr_rd_i | cr2_we_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) al_q <= 1'b0;
    else         al_q <= loss | (al_q & ~clr);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       mode_q <= '0;
    else if (loss)     mode_q <= '0;
    else if (cr2_we_i) mode_q <= mode_wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         hold_q <= 1'b0;
    else if (loss)       hold_q <= 1'b1;
    else if (byte_end_i) hold_q <= 1'b0;
  end

  assign al_o   = al_q;
  assign mode_o = mode_q;
  assign hold_o = hold_q;

endmodule

// File: rtl/i2c_arb_guard.sv
module i2c_arb_guard
  import i2c_arb_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  input  logic scl_drive_i,
  input  logic sda_drive_i,
  input  logic drive_slot_i,
  input  logic byte_end_i,
  input  logic dbr_wr_i,
  input  logic dbr_rd_i,
  input  logic cr2_we_i,
  input  logic mst_wdata_i,
  input  logic trx_wdata_i,
  output logic al_o,
  output logic mst_o,
  output logic trx_o,
  output logic sda_o,
  output logic scl_o
);

  localparam int BUS_W = $bits(bus_lvl_t);

  bus_lvl_t  bus_raw;
  bus_lvl_t  bus_sync;
  arb_mode_t mode_wdata;
  arb_mode_t mode;
  logic      scl_rise;
  logic      hold;

  assign bus_raw    = '{scl: scl_i, sda: sda_i};
  assign mode_wdata = '{mst: mst_wdata_i, trx: trx_wdata_i};

  i2c_arb_sync #(
    .WIDTH  (BUS_W),
    .STAGES (SYNC_STAGES),
    .RST_VAL(BUS_IDLE)
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (bus_raw),
    .q_o   (bus_sync)
  );

  i2c_arb_edge #(
    .RST_VAL(1'b1)
  ) u_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .lvl_i (bus_sync.scl),
    .rise_o(scl_rise)
  );

  i2c_arb_core u_core (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .scl_rise_i  (scl_rise),
    .sda_seen_i  (bus_sync.sda),
    .sda_drive_i (sda_drive_i),
    .drive_slot_i(drive_slot_i),
    .byte_end_i  (byte_end_i),
    .dbr_wr_i    (dbr_wr_i),
    .dbr_rd_i    (dbr_rd_i),
    .cr2_we_i    (cr2_we_i),
    .mode_wdata_i(mode_wdata),
    .al_o        (al_o),
    .mode_o      (mode),
    .hold_o      (hold)
  );

  assign mst_o = mode.mst;
  assign trx_o = mode.trx;
  // released pads after a loss: SDA for the byte, SCL while not master
  assign sda_o = hold ? 1'b1 : sda_drive_i;
  assign scl_o = mode.mst ? scl_drive_i : 1'b1;

endmodule

// File: rtl/i2c_arb_guard_chk.sv
module i2c_arb_guard_chk #(
  parameter int SYNC_STAGES = 2
) (
  input logic clk_i,
  input logic rst_ni,
  input logic scl_i,
  input logic dbr_wr_i,
  input logic dbr_rd_i,
  input logic cr2_we_i,
  input logic al_o,
  input logic mst_o,
  input logic trx_o,
  input logic sda_o,
  input logic scl_o
);

  logic any_clr;
  assign any_clr = dbr_wr_i | dbr_rd_i | cr2_we_i;

  assert_demote_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(al_o) |-> (!mst_o && !trx_o));

  assert_master_only_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(al_o) |-> $past(mst_o));

  assert_sticky_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (al_o && !any_clr) |=> al_o);

  assert_clear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (al_o && any_clr && !mst_o) |=> !al_o);

  assert_sda_release_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(al_o) |-> sda_o);

  assert_scl_release_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mst_o |-> scl_o);

  assert_rise_only_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(al_o) |-> $past(scl_i, SYNC_STAGES));

endmodule

bind i2c_arb_guard i2c_arb_guard_chk #(
  .SYNC_STAGES(SYNC_STAGES)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .scl_i   (scl_i),
  .dbr_wr_i(dbr_wr_i),
  .dbr_rd_i(dbr_rd_i),
  .cr2_we_i(cr2_we_i),
  .al_o    (al_o),
  .mst_o   (mst_o),
  .trx_o   (trx_o),
  .sda_o   (sda_o),
  .scl_o   (scl_o)
);

// File: tb/sim_i2c_arb_guard.sv
`timescale 1ns/1ps
module sim_i2c_arb_guard;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic scl_i = 1'b1, sda_i = 1'b1, scl_drive_i = 1'b1, sda_drive_i = 1'b1;
  logic drive_slot_i = 1'b0, byte_end_i = 1'b0;
  logic dbr_wr_i = 1'b0, dbr_rd_i = 1'b0, cr2_we_i = 1'b0;
  logic mst_wdata_i = 1'b0, trx_wdata_i = 1'b0;
  logic al_o, mst_o, trx_o, sda_o, scl_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  i2c_arb_guard u0 (
    .clk_i(clk), .rst_ni(rst_ni), .scl_i(scl_i), .sda_i(sda_i),
    .scl_drive_i(scl_drive_i), .sda_drive_i(sda_drive_i),
    .drive_slot_i(drive_slot_i), .byte_end_i(byte_end_i),
    .dbr_wr_i(dbr_wr_i), .dbr_rd_i(dbr_rd_i), .cr2_we_i(cr2_we_i),
    .mst_wdata_i(mst_wdata_i), .trx_wdata_i(trx_wdata_i),
    .al_o(al_o), .mst_o(mst_o), .trx_o(trx_o), .sda_o(sda_o), .scl_o(scl_o)
  );

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  // reference model: raw bus history, two-edge-old entry is the compared one
  logic [1:0] hist[$];
  logic m_al, m_mst, m_trx, m_hold;

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      hist = '{2'b11, 2'b11, 2'b11};
      m_al = 0; m_mst = 0; m_trx = 0; m_hold = 0;
    end else begin
      logic rise, seen, lost, wipe;
      hist.push_front({scl_i, sda_i});
      rise = hist[2][1] && !hist[3][1];
      seen = hist[2][0];
      void'(hist.pop_back());
      lost = m_mst && drive_slot_i && rise && (seen != sda_drive_i);
      wipe = dbr_wr_i || dbr_rd_i || cr2_we_i;
      if (lost) begin
        m_al = 1; m_mst = 0; m_trx = 0; m_hold = 1;
      end else begin
        if (wipe) m_al = 0;
        if (cr2_we_i) begin m_mst = mst_wdata_i; m_trx = trx_wdata_i; end
        if (byte_end_i) m_hold = 0;
      end
    end
  end

  always @(posedge clk) begin
    #1;
    if (rst_ni && !done) begin
      check("R2 flag vs model", al_o, m_al);
      check("R3 master bit vs model", mst_o, m_mst);
      check("R3 transmit bit vs model", trx_o, m_trx);
      check("R7 sda_o vs model", sda_o, m_hold ? 1'b1 : sda_drive_i);
      check("R8 scl_o vs model", scl_o, m_mst ? scl_drive_i : 1'b1);
    end
  end

  task automatic ctrl_write(input logic mst, input logic trx);
    @(negedge clk); cr2_we_i = 1; mst_wdata_i = mst; trx_wdata_i = trx;
    @(negedge clk); cr2_we_i = 0;
  endtask

  task automatic pulse_rd();
    @(negedge clk); dbr_rd_i = 1;
    @(negedge clk); dbr_rd_i = 0;
  endtask

  task automatic pulse_wr();
    @(negedge clk); dbr_wr_i = 1;
    @(negedge clk); dbr_wr_i = 0;
  endtask

  task automatic bus_bit(input logic drv, input logic seen, input logic slot);
    @(negedge clk); scl_i = 0; scl_drive_i = 0;
    repeat (3) @(negedge clk);
    sda_drive_i = drv; sda_i = seen; drive_slot_i = slot;
    repeat (3) @(negedge clk); scl_i = 1; scl_drive_i = 1;
    repeat (5) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    check("R1 flag after reset", al_o, 1'b0);
    check("R1 master after reset", mst_o, 1'b0);
    check("R1 transmit after reset", trx_o, 1'b0);
    check("R1 scl_o after reset", scl_o, 1'b1);
    check("R1 sda_o after reset", sda_o, 1'b1);

    ctrl_write(1, 1);
    check("R9 master loaded", mst_o, 1'b1);
    check("R9 transmit loaded", trx_o, 1'b1);
    scl_drive_i = 0; #1;
    check("R8 scl_o follows engine", scl_o, 1'b0);
    scl_drive_i = 1;

    bus_bit(1, 1, 1);
    bus_bit(0, 0, 1);
    check("R4 matching bits", al_o, 1'b0);
    bus_bit(1, 0, 0);
    check("R4 ack slot ignored", al_o, 1'b0);

    // SCL already high: mismatch without a new rising edge
    @(negedge clk); sda_drive_i = 1; drive_slot_i = 1; sda_i = 0;
    repeat (6) @(negedge clk);
    check("R10 no compare while SCL high", al_o, 1'b0);
    check("R10 still master", mst_o, 1'b1);
    sda_i = 1;

    bus_bit(0, 1, 1);
    check("R2 loss flagged", al_o, 1'b1);
    check("R3 master dropped", mst_o, 1'b0);
    check("R3 transmit dropped", trx_o, 1'b0);
    check("R7 sda released despite drive 0", sda_o, 1'b1);
    scl_drive_i = 0; #1;
    check("R8 scl released after loss", scl_o, 1'b1);
    repeat (8) @(negedge clk);
    check("R5 flag sticky", al_o, 1'b1);
    byte_end_i = 1; @(negedge clk); byte_end_i = 0;
    check("R7 sda follows engine after byte end", sda_o, 1'b0);
    pulse_rd();
    check("R5 cleared by data read", al_o, 1'b0);

    scl_drive_i = 1;
    ctrl_write(1, 1);
    bus_bit(1, 0, 1);
    check("R2 second loss", al_o, 1'b1);
    pulse_wr();
    check("R5 cleared by data write", al_o, 1'b0);

    ctrl_write(1, 1);
    bus_bit(1, 0, 1);
    check("R2 third loss", al_o, 1'b1);
    ctrl_write(1, 0);
    check("R5 cleared by control write", al_o, 1'b0);
    check("R9 master reloaded", mst_o, 1'b1);
    check("R9 transmit reloaded", trx_o, 1'b0);

    ctrl_write(0, 0);
    bus_bit(1, 0, 1);
    check("R4 no loss as slave", al_o, 1'b0);

    // clear strobe on the same edge as a loss
    ctrl_write(1, 1);
    @(negedge clk); scl_i = 0; scl_drive_i = 0;
    repeat (3) @(negedge clk); sda_drive_i = 1; sda_i = 0; drive_slot_i = 1;
    repeat (3) @(negedge clk); scl_i = 1; scl_drive_i = 1;
    @(posedge clk); @(posedge clk);
    @(negedge clk); cr2_we_i = 1; mst_wdata_i = 1; trx_wdata_i = 1;
    @(negedge clk); cr2_we_i = 0;
    check("R6 loss beats clear", al_o, 1'b1);
    check("R6 master stays dropped", mst_o, 1'b0);
    check("R6 transmit stays dropped", trx_o, 1'b0);

    repeat (4) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog R1-all: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule